// File: doc/BRIEF.md
# Column-Granular Partial Reconfiguration Command Sequencer

This block produces the ordered stream of 32-bit configuration words that rewrites a group of whole columns in a programmable fabric. A single start request carries the first column's address, the number of columns, the number of payload words and two small sets of optional command flags. The sequencer then emits a fixed sequence of words:

- a synchronization word;
- the chosen pre-commands;
- a frame-address write;
- a column-count write;
- a run of sixteen no-operation words, which gives the first column time for its internal reset;
- a data-register header followed by the payload;
- the chosen post-commands;
- a desynchronize command.

The payload is passed through from an upstream port, one word per handshake. Output words travel on a valid/ready handshake. Upstream stalls and downstream stalls therefore both propagate, and no word is lost or repeated. A running CRC-32 covers the data word of every register write. A request that is not aligned to a column, or that asks for zero columns, is refused with a one-cycle error pulse and produces no output.

Top module: `col_reconfig_seq`

## Requirements
- R1: After an accepted start, the first word offered is the synchronization word 0xAA995566. It is offered in the cycle after the start is sampled.
- R2: Each set pre-command flag adds a header 0x28008001 and then a command code. Flag bit0 selects shutdown (code 0x3) and flag bit1 selects hold-high (code 0x8). They are emitted in that order, after synchronization and before the address write.
- R3: The address write is header 0x28002001 followed by the start address. An address whose low 5 bits are nonzero is refused: `err_o` pulses for one cycle, in the cycle after the start, and no word is offered.
- R4: The column-count write is header 0x28012001 followed by {24'b0, count[7:0]}. Bits above bit 7 of `col_count_i` are ignored. A zero low byte is refused in the same way as in R3.
- R5: Exactly 16 words of 0x20000000 follow the column-count data word.
- R6: After the no-op run, a data header 0x28004000 carries the payload length in bits [10:0]. The payload words follow in order through the handshake, with none dropped or duplicated. A length of zero gives the header only.
- R7: Each set post-command flag adds a header 0x28008001 and then a code. Bit0 selects start (0x5) and bit1 selects deassert (0xA), in that order.
- R8: The stream ends with 0x28008001 and then the code 0xD. `done_o` is high for exactly the one cycle after that word is accepted, and `busy_o` is low in that cycle.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_data_o` hold their values in the next cycle.
- R10: `crc_o` is cleared when a start is accepted. It then folds in each accepted register-write data word: command codes, address, count word and payload. It uses CRC-32 with polynomial 0x04C11DB7, MSB first, no reflection and an initial value of 0. The value holds while idle.
- R11: A start request while busy is ignored, and the stream in progress is unchanged.
- R12: During and after reset, the block is idle: no valid output, `busy_o`, `done_o` and `err_o` all low, `pay_ready_o` low, and `crc_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request, sampled while idle |
| start_addr_i | input | 32 | First frame address of the starting column |
| col_count_i | input | 16 | Column count; only the low byte is significant |
| pre_cmd_i | input | 2 | Pre-command flags: bit0 shutdown, bit1 hold-high |
| post_cmd_i | input | 2 | Post-command flags: bit0 start, bit1 deassert |
| frame_len_i | input | 11 | Number of payload words |
| pay_data_i | input | 32 | Upstream payload word |
| pay_valid_i | input | 1 | Upstream payload word valid |
| pay_ready_o | output | 1 | Payload word taken this cycle |
| out_data_o | output | 32 | Configuration word |
| out_valid_o | output | 1 | Configuration word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse after the final word is accepted |
| err_o | output | 1 | One-cycle pulse for a refused request |
| crc_o | output | 32 | Running CRC over register-write data words |

## Verification
The results fall due at these points:

- **Start:** a start sampled at a rising edge shows its effect one edge later. The synchronization word is offered, or `err_o` is high, in the next cycle.
- **Words:** each accepted word moves the stream by one word at that edge.
- **Done:** `done_o` is due in the single cycle after the edge that accepts the desynchronize code, and `crc_o` is final from that cycle on.

The bench drives inputs and samples outputs at the falling edge. It records a word only when valid and ready were both high before the coming edge. It checks the refusal pulse one and two cycles after the start, and it checks `done_o`, `busy_o` and the CRC in the cycle after the final acceptance and in the cycle after that.

// File: rtl/colcfg_pkg.sv
package colcfg_pkg;

  localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
  localparam logic [31:0] NOP_WORD  = 32'h2000_0000;

  localparam logic [13:0] REG_FAR  = 14'd1;
  localparam logic [13:0] REG_DATA = 14'd2;
  localparam logic [13:0] REG_CMD  = 14'd4;
  localparam logic [13:0] REG_COLS = 14'd9;

  localparam logic [3:0] CMD_SHUT     = 4'h3;
  localparam logic [3:0] CMD_HOLD     = 4'h8;
  localparam logic [3:0] CMD_START    = 4'h5;
  localparam logic [3:0] CMD_DEASSERT = 4'hA;
  localparam logic [3:0] CMD_DESYNC   = 4'hD;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SYNC, ST_PRE_H, ST_PRE_D, ST_FAR_H, ST_FAR_D,
    ST_CNT_H, ST_CNT_D, ST_NOP, ST_DAT_H, ST_DAT,
    ST_POST_H, ST_POST_D, ST_DSY_H, ST_DSY_D
  } seq_state_t;

  // single-register write header: type 001, opcode 01 (write), register, count
  function automatic logic [31:0] wr_hdr(input logic [13:0] ra, input logic [10:0] n);
    return {3'b001, 2'b01, ra, 2'b00, n};
  endfunction

endpackage

// File: rtl/colcfg_rst_sync.sv
module colcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/colcfg_crc.sv
module colcfg_crc #(
  parameter int          W    = 32,
  parameter logic [31:0] POLY = 32'h04C1_1DB7
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, crc_d;

  function automatic logic [W-1:0] fold(input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] r;
    logic         fb;
    r = c;
    for (int i = W - 1; i >= 0; i--) begin
      fb = r[W-1] ^ d[i];
      r  = {r[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
    end
    return r;
  endfunction

  always_comb begin
    crc_d = crc_q;
    if (clr_i)     crc_d = '0;
    else if (en_i) crc_d = fold(crc_q, data_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)            crc_q <= '0;
    else if (clr_i || en_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/colcfg_ctrl.sv
module colcfg_ctrl
  import colcfg_pkg::*;
#(
  parameter int FRAME_BITS = 5,
  parameter int CNT_W      = 16,
  parameter int NOP_RUN    = 16,
  parameter int LEN_W      = 11,
  localparam int NW        = $clog2(NOP_RUN)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      addr_i,
  input  logic [CNT_W-1:0] cols_i,
  input  logic [1:0]       pre_i,
  input  logic [1:0]       post_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pay_valid_i,
  input  logic             out_ready_i,
  output seq_state_t       state_o,
  output logic [3:0]       cmd_o,
  output logic [31:0]      far_o,
  output logic [7:0]       cols_o,
  output logic [LEN_W-1:0] len_o,
  output logic             out_valid_o,
  output logic             pay_ready_o,
  output logic             pay_phase_o,
  output logic             crc_en_o,
  output logic             crc_clr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  seq_state_t       state_q, state_d;
  logic [1:0]       pre_q, pre_d, post_q, post_d;
  logic [NW-1:0]    nop_q, nop_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [31:0]      far_q;
  logic [7:0]       cols_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q, done_d, err_q, err_d;
  logic             req_ok, load, acc, data_word;
  seq_state_t       after_data;
  logic [CNT_W-9:0] unused_cols_hi;

  assign unused_cols_hi = cols_i[CNT_W-1:8];
  assign req_ok = (addr_i[FRAME_BITS-1:0] == '0) && (cols_i[7:0] != 8'd0);
  assign load   = (state_q == ST_IDLE) && start_i && req_ok;

  assign out_valid_o = (state_q == ST_DAT) ? pay_valid_i : (state_q != ST_IDLE);
  assign acc         = out_valid_o && out_ready_i;
  assign pay_phase_o = (state_q == ST_DAT);
  assign pay_ready_o = pay_phase_o && out_ready_i;

  always_comb begin
    unique case (state_q)
      ST_PRE_D, ST_FAR_D, ST_CNT_D, ST_DAT, ST_POST_D, ST_DSY_D: data_word = 1'b1;
      default:                                                   data_word = 1'b0;
    endcase
  end

  assign crc_en_o  = acc && data_word;
  assign crc_clr_o = load;

  always_comb begin
    unique case (state_q)
      ST_PRE_H, ST_PRE_D:   cmd_o = pre_q[0] ? CMD_SHUT : CMD_HOLD;
      ST_POST_H, ST_POST_D: cmd_o = post_q[0] ? CMD_START : CMD_DEASSERT;
      default:              cmd_o = CMD_DESYNC;
    endcase
  end

  assign after_data = (post_q != 2'b00) ? ST_POST_H : ST_DSY_H;

  always_comb begin
    state_d = state_q;
    pre_d   = pre_q;
    post_d  = post_q;
    nop_d   = nop_q;
    left_d  = left_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (req_ok) begin
            state_d = ST_SYNC;
            pre_d   = pre_i;
            post_d  = post_i;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_SYNC:   if (acc) state_d = (pre_q != 2'b00) ? ST_PRE_H : ST_FAR_H;
      ST_PRE_H:  if (acc) state_d = ST_PRE_D;
      ST_PRE_D: begin
        if (acc) begin
          pre_d   = pre_q & (pre_q - 2'd1);
          state_d = ((pre_q & (pre_q - 2'd1)) != 2'b00) ? ST_PRE_H : ST_FAR_H;
        end
      end
      ST_FAR_H:  if (acc) state_d = ST_FAR_D;
      ST_FAR_D:  if (acc) state_d = ST_CNT_H;
      ST_CNT_H:  if (acc) state_d = ST_CNT_D;
      ST_CNT_D: begin
        if (acc) begin
          state_d = ST_NOP;
          nop_d   = '0;
        end
      end
      ST_NOP: begin
        if (acc) begin
          nop_d = nop_q + NW'(1);
          if (nop_q == NW'(NOP_RUN - 1)) state_d = ST_DAT_H;
        end
      end
      ST_DAT_H: begin
        if (acc) begin
          if (len_q != '0) begin
            state_d = ST_DAT;
            left_d  = len_q;
          end else begin
            state_d = after_data;
          end
        end
      end
      ST_DAT: begin
        if (acc) begin
          left_d = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) state_d = after_data;
        end
      end
      ST_POST_H: if (acc) state_d = ST_POST_D;
      ST_POST_D: begin
        if (acc) begin
          post_d  = post_q & (post_q - 2'd1);
          state_d = ((post_q & (post_q - 2'd1)) != 2'b00) ? ST_POST_H : ST_DSY_H;
        end
      end
      ST_DSY_H:  if (acc) state_d = ST_DSY_D;
      ST_DSY_D: begin
        if (acc) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
      post_q  <= '0;
      nop_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pre_q   <= pre_d;
      post_q  <= post_d;
      nop_q   <= nop_d;
      left_q  <= left_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      far_q  <= '0;
      cols_q <= '0;
      len_q  <= '0;
    end else if (load) begin
      far_q  <= addr_i;
      cols_q <= cols_i[7:0];
      len_q  <= len_i;
    end
  end

  assign state_o = state_q;
  assign far_o   = far_q;
  assign cols_o  = cols_q;
  assign len_o   = len_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/colcfg_word_mux.sv
module colcfg_word_mux
  import colcfg_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  seq_state_t       state_i,
  input  logic [3:0]       cmd_i,
  input  logic [31:0]      far_i,
  input  logic [7:0]       cols_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      pay_data_i,
  output logic [31:0]      word_o
);
  always_comb begin
    unique case (state_i)
      ST_SYNC:                      word_o = SYNC_WORD;
      ST_PRE_H, ST_POST_H, ST_DSY_H: word_o = wr_hdr(REG_CMD, 11'd1);
      ST_PRE_D, ST_POST_D, ST_DSY_D: word_o = {28'd0, cmd_i};
      ST_FAR_H:                     word_o = wr_hdr(REG_FAR, 11'd1);
      ST_FAR_D:                     word_o = far_i;
      ST_CNT_H:                     word_o = wr_hdr(REG_COLS, 11'd1);
      ST_CNT_D:                     word_o = {24'd0, cols_i};
      ST_NOP:                       word_o = NOP_WORD;
      ST_DAT_H:                     word_o = wr_hdr(REG_DATA, 11'(len_i));
      ST_DAT:                       word_o = pay_data_i;
      default:                      word_o = 32'd0;
    endcase
  end
endmodule

// File: rtl/col_reconfig_seq.sv
module col_reconfig_seq
  import colcfg_pkg::*;
#(
  parameter int FRAME_BITS = 5,
  parameter int CNT_W      = 16,
  parameter int NOP_RUN    = 16,
  parameter int LEN_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [31:0]      start_addr_i,
  input  logic [CNT_W-1:0] col_count_i,
  input  logic [1:0]       pre_cmd_i,
  input  logic [1:0]       post_cmd_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [31:0]      pay_data_i,
  input  logic             pay_valid_i,
  output logic             pay_ready_o,
  output logic [31:0]      out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [31:0]      crc_o
);
  logic             rst_i_n;
  seq_state_t       state;
  logic [3:0]       cmd;
  logic [31:0]      far;
  logic [7:0]       cols;
  logic [LEN_W-1:0] len;
  logic             pay_phase, crc_en, crc_clr;

  colcfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  colcfg_ctrl #(
    .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W), .NOP_RUN(NOP_RUN), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_ni(rst_i_n), .start_i(start_i), .addr_i(start_addr_i),
    .cols_i(col_count_i), .pre_i(pre_cmd_i), .post_i(post_cmd_i), .len_i(frame_len_i),
    .pay_valid_i(pay_valid_i), .out_ready_i(out_ready_i), .state_o(state), .cmd_o(cmd),
    .far_o(far), .cols_o(cols), .len_o(len), .out_valid_o(out_valid_o),
    .pay_ready_o(pay_ready_o), .pay_phase_o(pay_phase), .crc_en_o(crc_en),
    .crc_clr_o(crc_clr), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  colcfg_word_mux #(.LEN_W(LEN_W)) u_mux (
    .state_i(state), .cmd_i(cmd), .far_i(far), .cols_i(cols), .len_i(len),
    .pay_data_i(pay_data_i), .word_o(out_data_o)
  );

  colcfg_crc #(.W(32), .POLY(32'h04C1_1DB7)) u_crc (
    .clk(clk), .rst_ni(rst_i_n), .clr_i(crc_clr), .en_i(crc_en),
    .data_i(out_data_o), .crc_o(crc_o)
  );
endmodule

// File: rtl/colcfg_chk.sv
module colcfg_chk
  import colcfg_pkg::*;
#(
  parameter int NOP_RUN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_data_o,
  input logic        pay_ready_o,
  input logic        pay_phase,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] crc_o
);
  localparam logic [31:0] DATA_HDR = wr_hdr(REG_DATA, 11'd0);
  localparam logic [31:0] COLS_HDR = wr_hdr(REG_COLS, 11'd1);

  logic       armed_q;
  logic [7:0] run_q;
  logic       acc;

  assign acc = out_valid_o && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      run_q   <= '0;
    end else if (acc) begin
      if (out_data_o == COLS_HDR) begin
        armed_q <= 1'b1;
        run_q   <= '0;
      end else if (armed_q && out_data_o == NOP_WORD) begin
        run_q <= run_q + 8'd1;
      end else if (armed_q && out_data_o[31:11] == DATA_HDR[31:11]) begin
        AST_NOP_RUN: assert (run_q == 8'(NOP_RUN)) else $error("nop run %0d", run_q); // R5
        armed_q <= 1'b0;
      end
    end
  end

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> out_valid_o && out_data_o == SYNC_WORD); // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !pay_phase) |=> (out_valid_o && $stable(out_data_o))); // R9
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!out_valid_o && !busy_o)); // R3
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8
  AST_PAY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !pay_ready_o); // R6
  AST_CRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(crc_o)); // R10
endmodule

bind col_reconfig_seq colcfg_chk #(.NOP_RUN(NOP_RUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .pay_ready_o(pay_ready_o), .pay_phase(pay_phase),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .crc_o(crc_o)
);

// File: tb/col_reconfig_seq_tb.sv
module col_reconfig_seq_tb;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] cols;
    logic [1:0]  pre;
    logic [1:0]  post;
    logic [10:0] len;
    logic        poke;
    logic        bad;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0040, 16'h0003, 2'b00, 2'b00, 11'd4, 1'b0, 1'b0},
    '{32'h0000_1A00, 16'h0101, 2'b11, 2'b11, 11'd6, 1'b0, 1'b0},
    '{32'h0000_0020, 16'h00FF, 2'b01, 2'b10, 11'd0, 1'b0, 1'b0},
    '{32'h0000_0021, 16'h0004, 2'b00, 2'b00, 11'd2, 1'b0, 1'b1},
    '{32'h0000_0100, 16'h0300, 2'b00, 2'b00, 11'd2, 1'b0, 1'b1},
    '{32'h0000_2000, 16'h0002, 2'b10, 2'b01, 11'd3, 1'b1, 1'b0},
    '{32'h2000_0000, 16'h0080, 2'b00, 2'b11, 11'd2, 1'b0, 1'b0}
  };

  logic        clk, rst_n, start_i, pay_valid_i, pay_ready_o, out_valid_o, out_ready_i;
  logic [31:0] start_addr_i, pay_data_i, out_data_o, crc_o;
  logic [15:0] col_count_i;
  logic [1:0]  pre_cmd_i, post_cmd_i;
  logic [10:0] frame_len_i;
  logic        busy_o, done_o, err_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [31:0] ew [64];
  string       et [64];
  int          ne;
  logic [31:0] ecrc;

  col_reconfig_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .col_count_i(col_count_i), .pre_cmd_i(pre_cmd_i), .post_cmd_i(post_cmd_i),
    .frame_len_i(frame_len_i), .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i),
    .pay_ready_o(pay_ready_o), .out_data_o(out_data_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .crc_o(crc_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c ^ d;
    repeat (32) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  task automatic push(input logic [31:0] w, input string tag, input bit fold);
    ew[ne] = w;
    et[ne] = tag;
    ne++;
    if (fold) ecrc = crc_step(ecrc, w);
  endtask

  function automatic logic [31:0] pay_word(input int v, input int i);
    return 32'hC0DE_0000 + 32'(v * 256 + i);
  endfunction

  task automatic build(input int v);
    vec_t c = VECS[v];
    ne = 0;
    ecrc = 32'd0;
    push(32'hAA99_5566, "R1", 0);
    if (c.pre[0]) begin push(32'h2800_8001, "R2", 0); push(32'h3, "R2", 1); end
    if (c.pre[1]) begin push(32'h2800_8001, "R2", 0); push(32'h8, "R2", 1); end
    push(32'h2800_2001, "R3", 0);
    push(c.addr, "R3", 1);
    push(32'h2801_2001, "R4", 0);
    push({24'd0, c.cols[7:0]}, "R4", 1);
    for (int i = 0; i < 16; i++) push(32'h2000_0000, "R5", 0);
    push(32'h2800_4000 | 32'(c.len), "R6", 0);
    for (int i = 0; i < int'(c.len); i++) push(pay_word(v, i), "R6", 1);
    if (c.post[0]) begin push(32'h2800_8001, "R7", 0); push(32'h5, "R7", 1); end
    if (c.post[1]) begin push(32'h2800_8001, "R7", 0); push(32'hA, "R7", 1); end
    push(32'h2800_8001, "R8", 0);
    push(32'hD, "R8", 1);
  endtask

  task automatic run_vec(input int v);
    vec_t c = VECS[v];
    int got = 0, pidx = 0, cyc = 0;
    bit ppend = 0, stall = 0, seen_done = 0;
    logic [31:0] prev_word = '0;
    string rtag;
    build(v);
    @(negedge clk);
    start_i = 1'b1; start_addr_i = c.addr; col_count_i = c.cols;
    pre_cmd_i = c.pre; post_cmd_i = c.post; frame_len_i = c.len;
    if (c.bad) begin
      rtag = (c.addr[4:0] != 5'd0) ? "R3" : "R4";
      @(negedge clk); start_i = 1'b0; #1;
      check(err_o === 1'b1, rtag, 32'(err_o), 32'd1);
      check(out_valid_o === 1'b0 && busy_o === 1'b0, rtag, 32'(out_valid_o), 32'd0);
      @(negedge clk); #1;
      check(err_o === 1'b0 && out_valid_o === 1'b0, rtag, 32'(err_o), 32'd0);
      return;
    end
    while (cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (c.poke && cyc == 8) begin
        start_i = 1'b1; start_addr_i = 32'h40; col_count_i = 16'h7;   // R11 ignored while busy
        pre_cmd_i = 2'b11; post_cmd_i = 2'b00; frame_len_i = 11'd1;
      end else start_i = 1'b0;
      out_ready_i = (v == 0) ? 1'b1 : (((cyc + v) % 4) != 0);
      if (!ppend) begin
        pay_valid_i = ((cyc % 5) != 2);
        pay_data_i  = pay_word(v, pidx);
      end
      #1;
      if (done_o) begin seen_done = 1; break; end
      if (stall) check(out_valid_o === 1'b1 && out_data_o === prev_word, "R9", out_data_o, prev_word);
      if (out_valid_o && out_ready_i) begin
        if (got < ne) check(out_data_o === ew[got], et[got], out_data_o, ew[got]);
        else check(1'b0, "R8", out_data_o, 32'd0);
        got++;
      end
      stall = out_valid_o && !out_ready_i;
      prev_word = out_data_o;
      if (pay_valid_i && pay_ready_o) begin pidx++; ppend = 0; end
      else if (pay_valid_i) ppend = 1;
    end
    check(seen_done, "R8", 32'(seen_done), 32'd1);
    check(got == ne, "R6", 32'(got), 32'(ne));
    check(busy_o === 1'b0, "R8", 32'(busy_o), 32'd0);
    check(crc_o === ecrc, "R10", crc_o, ecrc);
    @(negedge clk); #1;
    check(done_o === 1'b0 && out_valid_o === 1'b0, "R8", 32'(done_o), 32'd0);
    check(crc_o === ecrc, "R10", crc_o, ecrc);
    if (c.poke) check(busy_o === 1'b0, "R11", 32'(busy_o), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_addr_i = '0; col_count_i = '0;
    pre_cmd_i = '0; post_cmd_i = '0; frame_len_i = '0; pay_data_i = '0;
    pay_valid_i = 1'b0; out_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid_o === 1'b0 && busy_o === 1'b0, "R12", 32'(out_valid_o), 32'd0);
    check(done_o === 1'b0 && err_o === 1'b0 && pay_ready_o === 1'b0, "R12", 32'(done_o), 32'd0);
    check(crc_o === 32'd0, "R12", crc_o, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_vec(v);
      repeat (2) @(negedge clk);
    end

    // R12: reset during a run returns the block to idle
    @(negedge clk);
    start_i = 1'b1; start_addr_i = 32'h80; col_count_i = 16'h1;
    pre_cmd_i = 2'b00; post_cmd_i = 2'b00; frame_len_i = 11'd1; out_ready_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check(busy_o === 1'b1, "R12", 32'(busy_o), 32'd1);
    rst_n = 1'b0; #1;
    check(out_valid_o === 1'b0 && busy_o === 1'b0, "R12", 32'(out_valid_o), 32'd0);
    check(crc_o === 32'd0, "R12", crc_o, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk); #1;
    check(out_valid_o === 1'b0 && busy_o === 1'b0, "R12", 32'(busy_o), 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule